// File: doc/BRIEF.md
# Multi-mode timer waveform generator

The block is a 16-bit counter with two compare channels, A and B, that turns its count into waveforms on two output pins. A 4-bit mode code selects how the counter moves (wrapping upward, or sweeping up and back down), where its ceiling (TOP) comes from (a fixed value, the channel A compare register, or an externally supplied ceiling), and what kind of waveform is produced: plain compare events, single-slope fast PWM, or dual-slope symmetric PWM.

Each channel has a 2-bit output-mode field that, together with the mode code, decides what happens to its pin on a compare match and at TOP, and whether the pin is driven at all. The counter advances only on a clock-enable tick supplied from outside, so the block is paired with an external prescaler. Compare values are written through a shared data bus with one write strobe per channel. In the PWM modes these writes are buffered and take effect only at a defined point in the period, so a period never sees a half-updated duty cycle.

Top module: `tmr_wavegen`

## Requirements
- R1: While reset is low, and right after it is released, both pins, both output enables and the overflow pulse are 0, and the counter and all compare registers hold 0.
- R2: The mode code sets TOP as follows. Modes 0 and 13 use 0xFFFF. Modes 1 and 5 use 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF. Modes 4, 9, 11 and 15 use the active channel A compare value. Modes 8, 10, 12 and 14 use the `cap_top` input.
- R3: Modes 0, 4, 12 and 13 are non-PWM. The counter goes up by one per tick and returns to 0 on the tick after it equals TOP. On a compare match, output-mode 01 toggles the pin, 10 drives it low, 11 drives it high, and 00 does nothing. Compare writes take effect on the next clock.
- R4: Modes 5, 6, 7, 14 and 15 are fast PWM. The counter wraps to 0 after TOP, so the period is TOP+1 ticks. Output-mode 10 drives the pin low on a match and high at TOP. Output-mode 11 does the opposite.
- R5: In fast PWM with output-mode 10 or 11, a compare value equal to TOP produces no match action. Only the TOP action happens, so the pin stays constant.
- R6: Modes 1, 2, 3, 8, 9, 10 and 11 are dual-slope. The counter runs from 0 up to TOP and back down to 0, reversing at each end, so the period is 2·TOP ticks. Output-mode 10 drives the pin low on a match while counting up and high on a match while counting down. Output-mode 11 does the reverse.
- R7: In any PWM mode, output-mode 01 toggles channel A on each match when mode bit 3 is 1. In every other case, output-mode 01 leaves the pin undriven and unchanged, and this always applies to channel B.
- R8: The output enable of a channel is 1 for any nonzero output-mode in a non-PWM mode. In PWM modes it is 1 for output-modes 10 and 11, and for channel A with output-mode 01 when mode bit 3 is 1.
- R9: In PWM modes a compare write goes to a shadow register. The shadow is copied to the active register on a tick at BOTTOM (counter 0) in modes 8 and 9, and on a tick at TOP in all other PWM modes.
- R10: `ovf` is a one-clock pulse that follows a tick. It fires at the counter maximum 0xFFFF in non-PWM modes, at TOP in fast PWM, and at the lower turnaround in dual-slope modes.
- R11: A force strobe applies the channel's output-mode compare action on the next clock, with or without a tick, in non-PWM modes only. In PWM modes the strobe has no effect on the pin.
- R12: With `tick` low, the counter holds its value and no compare match or TOP action occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one counter step per clock in which it is high |
| mode | input | 4 | Waveform mode code |
| om_a | input | 2 | Channel A output-mode field |
| om_b | input | 2 | Channel B output-mode field |
| cmpa_we | input | 1 | Write strobe for the channel A compare value |
| cmpb_we | input | 1 | Write strobe for the channel B compare value |
| cmp_wdata | input | 16 | Compare write data |
| cap_top | input | 16 | Externally supplied TOP value |
| force_a | input | 1 | Force-compare strobe, channel A |
| force_b | input | 1 | Force-compare strobe, channel B |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A pin drive enable |
| oe_b | output | 1 | Channel B pin drive enable |
| ovf | output | 1 | Overflow pulse |

## Verification
The embedded assertions watch properties that hold on every cycle:
- the counter freezes when no tick arrives;
- a fast-PWM counter lands on 0 after a tick at TOP;
- a dual-slope counter away from its ends moves by exactly one;
- the overflow pulse only follows a tick;
- a pin cannot move without a tick or a non-PWM force.

Duty cycles and periods for each mode and output-mode combination, the buffered versus immediate loading of compare values, the compare-equals-TOP special case, and the overflow timing per mode family only show up over whole periods. The bench's scenarios measure those by counting high and low cycles on the pins and the spacing of overflow pulses.

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic [1:0]   om_a,
  input  logic [1:0]   om_b,
  input  logic         cmpa_we,
  input  logic         cmpb_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic [W-1:0] cap_top,
  input  logic         force_a,
  input  logic         force_b,
  output logic         wave_a,
  output logic         wave_b,
  output logic         oe_a,
  output logic         oe_b,
  output logic         ovf
);
  localparam logic [W-1:0] ZERO  = '0;
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXV  = {W{1'b1}};
  localparam logic [W-1:0] TOP8  = {{(W-8){1'b0}}, 8'hFF};
  localparam logic [W-1:0] TOP9  = {{(W-9){1'b0}}, 9'h1FF};
  localparam logic [W-1:0] TOP10 = {{(W-10){1'b0}}, 10'h3FF};

  logic [W-1:0] cnt, top, ocr_a, ocr_b, shd_a, shd_b;
  logic dir;
  logic fast, phase, pwm, at_top, at_bot, upd, hit_a, hit_b;

  assign fast  = mode inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
  assign phase = mode inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  assign pwm   = fast | phase;

  always_comb begin
    case (mode)
      4'd1, 4'd5:                top = TOP8;
      4'd2, 4'd6:                top = TOP9;
      4'd3, 4'd7:                top = TOP10;
      4'd4, 4'd9, 4'd11, 4'd15:  top = ocr_a;
      4'd8, 4'd10, 4'd12, 4'd14: top = cap_top;
      default:                   top = MAXV;
    endcase
  end

  assign at_top = (cnt == top);
  assign at_bot = (cnt == ZERO);
  assign upd    = tick & pwm & ((mode[3:1] == 3'b100) ? at_bot : at_top);
  assign hit_a  = tick & (cnt == ocr_a);
  assign hit_b  = tick & (cnt == ocr_b);

  assign oe_a = pwm ? (om_a[1] | (om_a == 2'b01 & mode[3])) : (om_a != 2'b00);
  assign oe_b = pwm ? om_b[1] : (om_b != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
      dir <= 1'b0;
    end else if (tick) begin
      if (!phase) begin
        dir <= 1'b0;
        cnt <= at_top ? ZERO : cnt + ONE;
      end else if (!dir) begin
        if (!at_top) cnt <= cnt + ONE;
        else if (!at_bot) begin
          dir <= 1'b1;
          cnt <= cnt - ONE;
        end
      end else if (!at_bot) begin
        cnt <= cnt - ONE;
      end else begin
        dir <= 1'b0;
        cnt <= cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_a <= ZERO;
      ocr_b <= ZERO;
      shd_a <= ZERO;
      shd_b <= ZERO;
    end else begin
      if (cmpa_we) shd_a <= cmp_wdata;
      if (cmpb_we) shd_b <= cmp_wdata;
      if (!pwm) begin
        if (cmpa_we) ocr_a <= cmp_wdata;
        if (cmpb_we) ocr_b <= cmp_wdata;
      end else if (upd) begin
        ocr_a <= shd_a;
        ocr_b <= shd_b;
      end
    end
  end

  function automatic logic wave_nxt(input logic cur, input logic [1:0] om,
                                    input logic hit, input logic frc, input logic tog_ok);
    logic r;
    r = cur;
    if (!pwm) begin
      if (hit || frc) begin
        case (om)
          2'b01:   r = ~cur;
          2'b10:   r = 1'b0;
          2'b11:   r = 1'b1;
          default: r = cur;
        endcase
      end
    end else if (om == 2'b01) begin
      if (tog_ok && hit) r = ~cur;
    end else if (om[1]) begin
      if (fast) begin
        if (tick && at_top) r = ~om[0];
        else if (hit)       r = om[0];
      end else if (hit) begin
        r = om[0] ^ dir;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_a <= 1'b0;
      wave_b <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      wave_a <= wave_nxt(wave_a, om_a, hit_a, force_a, mode[3]);
      wave_b <= wave_nxt(wave_b, om_b, hit_b, force_b, 1'b0);
      ovf    <= tick & (fast ? at_top : (phase ? (at_bot & dir) : (cnt == MAXV)));
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_fast_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && at_top) |=> (cnt == ZERO));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase && !at_bot && !at_top) |=>
      ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

  assert_ovf_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(tick));

  assert_wave_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(force_a && !pwm)) |=> $stable(wave_a));
endmodule

// File: tb/tmr_wavegen_tb.sv
`timescale 1ns/1ps
module tmr_wavegen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] om_a = '0, om_b = '0;
  logic cmpa_we = 1'b0, cmpb_we = 1'b0;
  logic [15:0] cmp_wdata = '0, cap_top = '0;
  logic force_a = 1'b0, force_b = 1'b0;
  logic wave_a, wave_b, oe_a, oe_b, ovf;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .om_a(om_a), .om_b(om_b),
    .cmpa_we(cmpa_we), .cmpb_we(cmpb_we), .cmp_wdata(cmp_wdata), .cap_top(cap_top),
    .force_a(force_a), .force_b(force_b), .wave_a(wave_a), .wave_b(wave_b),
    .oe_a(oe_a), .oe_b(oe_b), .ovf(ovf)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [1:0]  om;
    logic        ch;
    logic [15:0] ocr;
    logic [15:0] cap;
    logic [15:0] hi;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  2'b01, 1'b0, 16'd9,     16'd0,   16'd10,  16'd20},   // R3 R2 CTC toggle, TOP = compare A
    '{4'd12, 2'b01, 1'b0, 16'd24,    16'd24,  16'd25,  16'd50},   // R3 R2 CTC toggle, TOP = cap_top
    '{4'd5,  2'b10, 1'b0, 16'h0040,  16'd0,   16'd65,  16'd256},  // R4 fast 8-bit, clear on match
    '{4'd5,  2'b11, 1'b0, 16'h0040,  16'd0,   16'd191, 16'd256},  // R4 fast 8-bit, set on match
    '{4'd14, 2'b10, 1'b0, 16'd30,    16'd99,  16'd31,  16'd100},  // R4 R2 fast, TOP = cap_top
    '{4'd14, 2'b11, 1'b1, 16'd30,    16'd99,  16'd69,  16'd100},  // R4 channel B
    '{4'd15, 2'b01, 1'b0, 16'd49,    16'd0,   16'd50,  16'd100},  // R7 fast toggle on A
    '{4'd1,  2'b10, 1'b0, 16'h0040,  16'd0,   16'd128, 16'd510},  // R6 dual-slope 8-bit
    '{4'd1,  2'b11, 1'b1, 16'h0040,  16'd0,   16'd382, 16'd510},  // R6 inverted, channel B
    '{4'd10, 2'b10, 1'b0, 16'd50,    16'd200, 16'd100, 16'd400},  // R6 TOP = cap_top
    '{4'd8,  2'b10, 1'b0, 16'd75,    16'd150, 16'd150, 16'd300},  // R6 R9 load at bottom
    '{4'd11, 2'b01, 1'b0, 16'd60,    16'd0,   16'd120, 16'd240},  // R7 dual-slope toggle on A
    '{4'd3,  2'b10, 1'b0, 16'h0100,  16'd0,   16'd512, 16'd2046}  // R2 R6 10-bit TOP
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob,
                       input logic [15:0] ocr, input logic [15:0] cap, input logic tk);
    rst_n = 1'b0; tick = 1'b0; force_a = 1'b0; force_b = 1'b0;
    cmpa_we = 1'b0; cmpb_we = 1'b0;
    mode = m; om_a = oa; om_b = ob; cap_top = cap; cmp_wdata = ocr;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; tick = tk; cmpa_we = 1'b1; cmpb_we = 1'b1;
    @(negedge clk);
    cmpa_we = 1'b0; cmpb_we = 1'b0;
  endtask

  function automatic logic pick(input logic ch);
    return ch ? wave_b : wave_a;
  endfunction

  task automatic measure(input logic ch, output int hi, output int per);
    int n;
    n = 0;
    while (pick(ch) !== 1'b0 && n < 10000) begin @(negedge clk); n++; end
    while (pick(ch) !== 1'b1 && n < 10000) begin @(negedge clk); n++; end
    hi = 0;
    while (pick(ch) === 1'b1 && hi < 10000) begin @(negedge clk); hi++; end
    per = hi;
    while (pick(ch) === 1'b0 && per < 10000) begin @(negedge clk); per++; end
  endtask

  task automatic ovf_gap(output int gap);
    int n;
    n = 0;
    while (ovf !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
    @(negedge clk);
    gap = 1;
    while (ovf !== 1'b1 && gap < 70000) begin @(negedge clk); gap++; end
  endtask

  task automatic strobe(input logic a, input logic b);
    force_a = a; force_b = b;
    @(negedge clk);
    force_a = 1'b0; force_b = 1'b0;
  endtask

  task automatic oe_case(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob,
                         input logic ea, input logic eb);
    mode = m; om_a = oa; om_b = ob;
    #1;
    chk("R8 oe_a", int'(oe_a), int'(ea));
    chk("R8 oe_b", int'(oe_b), int'(eb));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, n, gap;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 wave_a", int'(wave_a), 0);
    chk("R1 wave_b", int'(wave_b), 0);
    chk("R1 oe_a", int'(oe_a), 0);
    chk("R1 oe_b", int'(oe_b), 0);
    chk("R1 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ovf after release", int'(ovf), 0);

    for (int i = 0; i < NV; i++) begin
      start(VECS[i].m, VECS[i].ch ? 2'b00 : VECS[i].om, VECS[i].ch ? VECS[i].om : 2'b00,
            VECS[i].ocr, VECS[i].cap, 1'b1);
      measure(VECS[i].ch, hi, per);
      measure(VECS[i].ch, hi, per);
      chk($sformatf("vector %0d high time", i), hi, int'(VECS[i].hi));
      chk($sformatf("vector %0d period", i), per, int'(VECS[i].per));
    end

    // R12 no tick, no match
    start(4'd4, 2'b01, 2'b00, 16'd0, 16'd0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R12 pin held without tick", int'(wave_a), 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R12 single tick matches", int'(wave_a), 1);

    // R11 force strobes in non-PWM and PWM
    start(4'd0, 2'b11, 2'b11, 16'h1234, 16'd0, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R11 force set A", int'(wave_a), 1);
    om_a = 2'b10; strobe(1'b1, 1'b0);
    chk("R11 force clear A", int'(wave_a), 0);
    om_a = 2'b01; strobe(1'b1, 1'b0);
    chk("R11 force toggle A", int'(wave_a), 1);
    strobe(1'b0, 1'b1);
    chk("R11 force set B", int'(wave_b), 1);
    mode = 4'd5; om_a = 2'b10; strobe(1'b1, 1'b0);
    chk("R11 force ignored in PWM", int'(wave_a), 1);

    // R9 buffered compare in fast PWM
    start(4'd5, 2'b11, 2'b00, 16'd3, 16'd0, 1'b0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R9 old active value still matched", int'(wave_a), 1);
    tick = 1'b1;
    measure(1'b0, hi, per);
    measure(1'b0, hi, per);
    chk("R9 new value after TOP, high", hi, 252);
    chk("R9 new value after TOP, period", per, 256);

    // R5 compare equal to TOP in fast PWM
    start(4'd5, 2'b10, 2'b00, 16'h00FF, 16'd0, 1'b1);
    repeat (300) @(negedge clk);
    n = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (wave_a !== 1'b1) n++; end
    chk("R5 pin constant when compare equals TOP", n, 0);

    // R7 code 01 undriven cases
    start(4'd15, 2'b00, 2'b01, 16'd49, 16'd0, 1'b1);
    n = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (wave_b !== 1'b0) n++; end
    chk("R7 channel B reserved in toggle mode", n, 0);
    start(4'd5, 2'b01, 2'b00, 16'h0040, 16'd0, 1'b1);
    n = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (wave_a !== 1'b0) n++; end
    chk("R7 code 01 inert when mode bit 3 is 0", n, 0);

    // R10 overflow timing
    start(4'd0, 2'b00, 2'b00, 16'd0, 16'd0, 1'b1);
    n = 1;
    while (ovf !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
    chk("R10 non-PWM overflow at MAX", n, 65536);
    @(negedge clk);
    chk("R10 pulse is one clock", int'(ovf), 0);
    start(4'd5, 2'b00, 2'b00, 16'd0, 16'd0, 1'b1);
    ovf_gap(gap);
    chk("R10 fast PWM overflow at TOP", gap, 256);
    start(4'd1, 2'b00, 2'b00, 16'd0, 16'd0, 1'b1);
    ovf_gap(gap);
    chk("R10 dual-slope overflow at bottom", gap, 510);
    start(4'd8, 2'b00, 2'b00, 16'd0, 16'd150, 1'b1);
    ovf_gap(gap);
    chk("R10 mode 8 overflow at bottom", gap, 300);
    start(4'd4, 2'b00, 2'b00, 16'd9, 16'd0, 1'b1);
    n = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (ovf === 1'b1) n++; end
    chk("R10 no overflow below MAX in CTC", n, 0);

    // R8 output enables
    @(negedge clk);
    oe_case(4'd0,  2'b00, 2'b00, 1'b0, 1'b0);
    oe_case(4'd0,  2'b01, 2'b10, 1'b1, 1'b1);
    oe_case(4'd5,  2'b01, 2'b01, 1'b0, 1'b0);
    oe_case(4'd15, 2'b01, 2'b01, 1'b1, 1'b0);
    oe_case(4'd1,  2'b11, 2'b10, 1'b1, 1'b1);
    oe_case(4'd9,  2'b01, 2'b00, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule